// File: doc/BRIEF.md
# Floating-Point Load Address Generator

This block forms the effective address for the floating-point load family and decides whether the base register is written back. Each request names one of four address forms with a 2-bit selector, gives the base register index and value, the index register value and a 16-bit displacement. The block adds a base term to an offset term and presents the result one clock later, along with a base-register writeback request and a flag for an illegal form.

There are two base-term rules. For forms without update, a base index of zero stands for the constant zero and does not read the register. For update forms the register contents are always used, and the sum is written back into that register. An update form that names register zero is illegal. It raises the invalid flag and never writes back. Memory access, data conversion and the register file sit in neighbouring blocks.

Top module: `fp_load_agen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `out_wb_en` and `out_invalid` are low after that edge, whatever `in_valid` is.
- R2: A form without update (`in_form[1]`=0) whose `in_base_idx` is 0 uses zero as the base term, so `out_ea` equals the offset term alone.
- R3: A form without update whose `in_base_idx` is nonzero uses `in_base_val` as the base term.
- R4: A displacement form (`in_form[0]`=0) uses `in_disp` sign-extended to 64 bits from its bit 15 as the offset term.
- R5: An indexed form (`in_form[0]`=1) uses the full 64-bit `in_index_val` as the offset term.
- R6: An update form (`in_form[1]`=1) uses `in_base_val` as the base term, even when `in_base_idx` is 0.
- R7: An update form with a nonzero `in_base_idx` raises `out_wb_en`, with `out_wb_idx` equal to `in_base_idx` and `out_wb_data` equal to `out_ea`. A form without update leaves `out_wb_en` low.
- R8: An update form with `in_base_idx` equal to 0 raises `out_invalid` and holds `out_wb_en` low. All other forms leave `out_invalid` low.
- R9: The addition is taken modulo 2^64, and any carry out of bit 63 is dropped.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results appear in that cycle. After a cycle with `in_valid` low, `out_valid`, `out_wb_en` and `out_invalid` are low and `out_ea` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_form | input | 2 | Bit 0: indexed; bit 1: update |
| in_base_idx | input | 5 | Base register index |
| in_base_val | input | 64 | Base register contents |
| in_index_val | input | 64 | Index register contents |
| in_disp | input | 16 | Signed displacement |
| out_valid | output | 1 | Result present this cycle |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Write the base register back |
| out_wb_idx | output | 5 | Base register to write |
| out_wb_data | output | 64 | Value to write back |
| out_invalid | output | 1 | Illegal form: update with base index 0 |

## Verification
An address writeback and the invalid-form decision come from the same request in the same cycle, so they could both fire at once. The sweep runs every form against base indices 0, 1 and 31, back to back. It checks that an update form with index 0 still produces an address from the register contents, raises `out_invalid` and leaves `out_wb_en` low. A neighbouring update request with a nonzero index must write back the same address it reports. Base and offset values are chosen so that some sums wrap past 2^64.

// File: rtl/fp_agen_pkg.sv
// Package: fp_agen_pkg
// Shared constants and helpers for the load address generator.
// Assumes the 2-bit form selector layout: bit 0 indexed, bit 1 update.
package fp_agen_pkg;
    localparam int FORM_W         = 2;
    localparam int FORM_BIT_INDEX = 0;
    localparam int FORM_BIT_UPD   = 1;

    // Returns 1 when the selector names an indexed form.
    function automatic logic form_is_indexed(input logic [FORM_W-1:0] f);
        return f[FORM_BIT_INDEX];
    endfunction

    // Returns 1 when the selector names an update form.
    function automatic logic form_is_update(input logic [FORM_W-1:0] f);
        return f[FORM_BIT_UPD];
    endfunction
endpackage

// File: rtl/agen_base_sel.sv
// Module: agen_base_sel
// Picks the base term of the address and classifies the request.
// For forms without update, index zero gives the constant zero. Update
// forms always read the register and are illegal with index zero.
// Purely combinational; the caller registers the results.
module agen_base_sel #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             update,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]  base_val,
    output logic [XLEN-1:0]  base_term,
    output logic             form_bad,
    output logic             wb_req
);
    logic idx_zero;

    // Detect the register-zero encoding.
    always_comb idx_zero = (base_idx == '0);

    // Select the base term and decide between writeback and invalid.
    always_comb begin
        base_term = base_val;
        form_bad  = 1'b0;
        wb_req    = 1'b0;
        if (update) begin
            form_bad = idx_zero;
            wb_req   = !idx_zero;
        end else if (idx_zero) begin
            base_term = '0;
        end
    end
endmodule

// File: rtl/agen_offset_sel.sv
// Module: agen_offset_sel
// Chooses the offset term: the sign-extended displacement or the full
// index register value. Assumes DISP_W is not larger than XLEN.
module agen_offset_sel #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16
) (
    input  logic              indexed,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   index_val,
    output logic [XLEN-1:0]   offset
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            // Replicate the displacement sign bit into the upper bits.
            always_comb disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_full
            // The displacement already fills the address width.
            always_comb disp_ext = disp;
        end
    endgenerate

    // Choose between the index register and the displacement.
    always_comb offset = indexed ? index_val : disp_ext;
endmodule

// File: rtl/agen_adder.sv
// Module: agen_adder
// Adds the base and offset terms modulo 2^XLEN using a ripple of
// LANE_W-bit lanes. The carry out of the top lane is dropped.
// Assumes LANE_W divides XLEN.
module agen_adder #(
    parameter int XLEN   = 64,
    parameter int LANE_W = 16
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum
);
    localparam int LANES = XLEN / LANE_W;

    logic [LANES:0] carry;

    // The lowest lane has no carry in.
    always_comb carry[0] = 1'b0;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W:0] lane_sum;
            // Add one lane together with the carry from the lane below.
            always_comb begin
                lane_sum = {1'b0, a[g*LANE_W +: LANE_W]}
                         + {1'b0, b[g*LANE_W +: LANE_W]}
                         + {{LANE_W{1'b0}}, carry[g]};
                sum[g*LANE_W +: LANE_W] = lane_sum[LANE_W-1:0];
                carry[g+1] = lane_sum[LANE_W];
            end
        end
    endgenerate

    logic carry_dropped;
    // The top carry is discarded because the sum wraps.
    always_comb carry_dropped = carry[LANES];
    wire unused_ok = &{1'b0, carry_dropped};
endmodule

// File: rtl/agen_out_stage.sv
// Module: agen_out_stage
// Output register stage. The valid, writeback and invalid flags clear on
// synchronous active-low reset and drop in any cycle without a request.
// The data fields load only on a request and otherwise hold.
module agen_out_stage #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [XLEN-1:0]  req_ea,
    input  logic             req_wb,
    input  logic             req_bad,
    input  logic [IDX_W-1:0] req_idx,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_ea,
    output logic             out_wb_en,
    output logic [IDX_W-1:0] out_wb_idx,
    output logic [XLEN-1:0]  out_wb_data,
    output logic             out_invalid
);
    // Control flags: cleared on reset, follow the request otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_wb_en   <= 1'b0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= req_valid;
            out_wb_en   <= req_valid && req_wb;
            out_invalid <= req_valid && req_bad;
        end
    end

    // Data fields: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (req_valid) begin
            out_ea      <= req_ea;
            out_wb_data <= req_ea;
            out_wb_idx  <= req_idx;
        end
    end

    // R8: writeback and the invalid flag never appear together.
    p_wb_not_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_wb_en && out_invalid));

    // R7: a writeback is only ever part of a valid result.
    p_wb_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> out_valid);
endmodule

// File: rtl/fp_load_agen.sv
// Module: fp_load_agen
// Top of the floating-point load address generator. It combines the base
// and offset terms, adds them modulo 2^XLEN and registers the address,
// the writeback request and the invalid flag for one cycle.
// Assumes the form selector layout defined in fp_agen_pkg.
module fp_load_agen
    import fp_agen_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int IDX_W  = 5,
    parameter int DISP_W = 16,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_form,
    input  logic [IDX_W-1:0]  in_base_idx,
    input  logic [XLEN-1:0]   in_base_val,
    input  logic [XLEN-1:0]   in_index_val,
    input  logic [DISP_W-1:0] in_disp,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_ea,
    output logic              out_wb_en,
    output logic [IDX_W-1:0]  out_wb_idx,
    output logic [XLEN-1:0]   out_wb_data,
    output logic              out_invalid
);
    logic            is_upd;
    logic            is_idx;
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] ea_next;
    logic            form_bad;
    logic            wb_req;

    // Decode the form selector.
    always_comb begin
        is_upd = form_is_update(in_form);
        is_idx = form_is_indexed(in_form);
    end

    agen_base_sel #(.XLEN(XLEN), .IDX_W(IDX_W)) u_base (
        .update    (is_upd),
        .base_idx  (in_base_idx),
        .base_val  (in_base_val),
        .base_term (base_term),
        .form_bad  (form_bad),
        .wb_req    (wb_req)
    );

    agen_offset_sel #(.XLEN(XLEN), .DISP_W(DISP_W)) u_off (
        .indexed   (is_idx),
        .disp      (in_disp),
        .index_val (in_index_val),
        .offset    (offset)
    );

    agen_adder #(.XLEN(XLEN), .LANE_W(LANE_W)) u_add (
        .a   (base_term),
        .b   (offset),
        .sum (ea_next)
    );

    agen_out_stage #(.XLEN(XLEN), .IDX_W(IDX_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (in_valid),
        .req_ea      (ea_next),
        .req_wb      (wb_req),
        .req_bad     (form_bad),
        .req_idx     (in_base_idx),
        .out_valid   (out_valid),
        .out_ea      (out_ea),
        .out_wb_en   (out_wb_en),
        .out_wb_idx  (out_wb_idx),
        .out_wb_data (out_wb_data),
        .out_invalid (out_invalid)
    );

    // R10: a request produces a valid result on the next cycle.
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: an idle cycle produces no result and holds the address.
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wb_en && !out_invalid && $stable(out_ea)));

    // R2: without update, register zero means the address is the offset alone.
    p_zero_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_upd && in_base_idx == '0) |=> out_ea == $past(offset));

    // R8: an update form naming register zero is flagged and does not write back.
    p_upd_zero_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_upd && in_base_idx == '0) |=> (out_invalid && !out_wb_en));

    // R7: an update form with a real base register requests writeback of it.
    p_upd_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_upd && in_base_idx != '0)
        |=> (out_wb_en && out_wb_idx == $past(in_base_idx)));

    // R6: an update form with index zero still adds the register contents.
    p_upd_uses_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_upd) |=> out_ea == $past(in_base_val) + $past(offset));
endmodule

// File: tb/fp_load_agen_bench.sv
// Bench: sweeps every form against a grid of base indices, base values,
// index values and displacements, computing the expected results directly.
module fp_load_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_form = '0;
    logic [4:0]  in_base_idx = '0;
    logic [63:0] in_base_val = '0;
    logic [63:0] in_index_val = '0;
    logic [15:0] in_disp = '0;
    logic        out_valid;
    logic [63:0] out_ea;
    logic        out_wb_en;
    logic [4:0]  out_wb_idx;
    logic [63:0] out_wb_data;
    logic        out_invalid;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    fp_load_agen u_fp_load_agen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
        .in_base_idx(in_base_idx), .in_base_val(in_base_val),
        .in_index_val(in_index_val), .in_disp(in_disp),
        .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en),
        .out_wb_idx(out_wb_idx), .out_wb_data(out_wb_data),
        .out_invalid(out_invalid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [63:0] bases [4] = '{64'h0, 64'h0000_0000_1000_0000,
                              64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000};
    logic [63:0] idxvals [4] = '{64'h0, 64'h0000_0000_0000_0024,
                                64'hFFFF_FFFF_FFFF_FFFC, 64'h8000_0000_0000_0008};
    logic [15:0] disps [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
    logic [4:0]  idxs [3] = '{5'd0, 5'd1, 5'd31};

    // Expected results of the request now in flight.
    logic        pend = 1'b0;
    logic [63:0] e_ea;
    logic        e_wb, e_bad, e_idx_form, e_carry;
    logic [4:0]  e_widx;
    string       e_base_tag;

    task automatic check_pending();
        chk("R10 out_valid", {63'b0, out_valid}, 64'd1);
        chk(e_base_tag, out_ea, e_ea);
        chk(e_idx_form ? "R5 ea" : "R4 ea", out_ea, e_ea);
        if (e_carry) chk("R9 wrap ea", out_ea, e_ea);
        chk("R7 wb_en", {63'b0, out_wb_en}, {63'b0, e_wb});
        chk("R8 invalid", {63'b0, out_invalid}, {63'b0, e_bad});
        if (e_wb) begin
            chk("R7 wb_idx", {59'b0, out_wb_idx}, {59'b0, e_widx});
            chk("R7 wb_data", out_wb_data, e_ea);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] bterm, off;
        logic [64:0] wide;
        logic [63:0] held;
        // R1: reset dominates an incoming request.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {63'b0, out_valid}, 64'd0);
        chk("R1 wb_en", {63'b0, out_wb_en}, 64'd0);
        chk("R1 invalid", {63'b0, out_invalid}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {63'b0, out_valid}, 64'd0);

        for (int f = 0; f < 4; f++)
        for (int i = 0; i < 3; i++)
        for (int b = 0; b < 4; b++)
        for (int x = 0; x < 4; x++) begin
            for (int d = 0; d < 5; d++) begin
                @(negedge clk);
                if (pend) check_pending();
                in_valid     = 1'b1;
                in_form      = f[1:0];
                in_base_idx  = idxs[i];
                in_base_val  = bases[b];
                in_index_val = idxvals[x];
                in_disp      = disps[d];
                bterm = (!f[1] && idxs[i] == 5'd0) ? 64'd0 : bases[b];
                off   = f[0] ? idxvals[x] : {{48{disps[d][15]}}, disps[d]};
                wide  = {1'b0, bterm} + {1'b0, off};
                e_ea       = wide[63:0];
                e_carry    = wide[64];
                e_idx_form = f[0];
                e_wb       = f[1] && idxs[i] != 5'd0;
                e_bad      = f[1] && idxs[i] == 5'd0;
                e_widx     = idxs[i];
                e_base_tag = f[1] ? "R6 ea" : (idxs[i] == 5'd0 ? "R2 ea" : "R3 ea");
                pend = 1'b1;
            end
            @(negedge clk);
            check_pending();
            pend = 1'b0;
            held = e_ea;
            in_valid = 1'b0;
            in_base_val = ~in_base_val;
            in_form = 2'b11;
            in_base_idx = 5'd0;
            @(negedge clk);
            chk("R10 idle valid", {63'b0, out_valid}, 64'd0);
            chk("R10 idle wb_en", {63'b0, out_wb_en}, 64'd0);
            chk("R10 idle invalid", {63'b0, out_invalid}, 64'd0);
            chk("R10 idle ea held", out_ea, held);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule